// File: doc/BRIEF.md
# Selectable Multiphase Clock Generator

This block derives four related clock outputs from a stream of master-rate ticks. The ticks arrive as a one-cycle enable on the system clock and stand in for an oscillator. A prescaler first thins the ticks by a ratio of 1, 10 or 100. A phase state machine then steps one of three output patterns on each surviving (prescaled) tick: a complementary pair repeated on all four outputs, three one-third-duty outputs spaced 120 degrees apart, or four half-duty outputs in 90-degree quadrature. All outputs are registers on the system clock.

Each prescaled tick is one step of a pattern. A half period of the 2-phase pattern is one step. The 3-phase and 4-phase patterns add a further divide by 3 and 4, so the output period is 2·N·M master ticks (M = 1, 3 or 4). If either select input changes, the block restarts: the counter and pattern clear, every output drops low, and the new pattern begins again from its first step.

The phase state machine has four states. `ST_IDLE` holds all outputs low after reset or a restart. `ST_TWO`, `ST_THREE` and `ST_FOUR` run the three patterns. The transition IDLE→TWO/THREE/FOUR fires on the first prescaled tick and picks the state from the latched phase mode. The transition from any state back to IDLE fires on a restart. Otherwise each state stays where it is.

Top module: `mpclk_gen`

## Requirements
- R1: After reset every output is low, and stays low until the first prescaled tick.
- R2: Divide code 00 gives a ratio of 1, 01 gives 10, and 10 gives 100. The pattern advances only on the tick that completes each group of N ticks, counted from reset or restart.
- R3: Phase code 00 (2-phase): the first prescaled tick raises output 1, and each later one toggles it. Output 2 is the inverse of output 1, output 3 copies output 1 and output 4 copies output 2. Bit i of `phase_out` is output i+1.
- R4: Phase code 01 (3-phase): one high bit moves from output 1 to output 2 to output 3 and back. Each output stays high for 2 prescaled ticks, which gives a period of 6 prescaled ticks, and output 4 stays low.
- R5: Phase code 10 (4-phase): outputs follow a twisted-ring sequence. Each output is high for 4 of every 8 prescaled ticks, and output k+1 rises and falls one prescaled tick after output k.
- R6: In 3-phase and 4-phase modes no two outputs rise in the same cycle, and no two fall in the same cycle. The cycle that ends a restart is excepted.
- R7: A change of the effective divide or phase setting drops all outputs low on the next cycle. It also clears the prescaler, and a tick in that cycle is not counted.
- R8: Code 11 acts as code 10 on both selects, so switching between 10 and 11 causes no restart.
- R9: Between prescaled ticks, with no restart, every output holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_en | input | 1 | Master-rate tick, one cycle wide |
| div_code | input | 2 | Prescale select: 00 ÷1, 01 ÷10, 10/11 ÷100 |
| phase_code | input | 2 | Pattern select: 00 2-phase, 01 3-phase, 10/11 4-phase |
| phase_out | output | 4 | Clock outputs; bit 0 is output 1 |

## Verification
A restart and a prescaled tick can fall in the same cycle. This happens when a select input changes on the very tick that would complete a group of N. The bench provokes it by changing settings mid-run, with ticks on every cycle, so that some changes land on a completing tick. A behavioural model drops that tick and clears its count. The outputs must then be low on the next cycle, and the first step of the new pattern must come N ticks later, never earlier. The same cycle-by-cycle comparison also judges switches between codes 10 and 11, where a restart must not happen at all.

// File: rtl/mpclk_pkg.sv
package mpclk_pkg;

    localparam int NUM_PH = 4;

    typedef enum logic [1:0] {
        DIV_ONE  = 2'd0,
        DIV_MID  = 2'd1,
        DIV_HIGH = 2'd2
    } div_e;

    typedef enum logic [1:0] {
        PH_TWO   = 2'd0,
        PH_THREE = 2'd1,
        PH_FOUR  = 2'd2
    } ph_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_TWO   = 2'd1,
        ST_THREE = 2'd2,
        ST_FOUR  = 2'd3
    } st_e;

    // Code 11 folds onto the last legal setting.
    function automatic div_e decode_div(input logic [1:0] code);
        case (code)
            2'b00:   return DIV_ONE;
            2'b01:   return DIV_MID;
            default: return DIV_HIGH;
        endcase
    endfunction

    function automatic ph_e decode_ph(input logic [1:0] code);
        case (code)
            2'b00:   return PH_TWO;
            2'b01:   return PH_THREE;
            default: return PH_FOUR;
        endcase
    endfunction

endpackage

// File: rtl/mpclk_cfg.sv
module mpclk_cfg
    import mpclk_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] div_code,
    input  logic [1:0] phase_code,
    output div_e       cfg_div,
    output ph_e        cfg_ph,
    output logic       restart
);

    div_e div_dec;
    ph_e  ph_dec;
    div_e div_q;
    ph_e  ph_q;

    always_comb begin
        div_dec = decode_div(div_code);
        ph_dec  = decode_ph(phase_code);
        restart = (div_dec != div_q) || (ph_dec != ph_q);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= DIV_ONE;
            ph_q  <= PH_TWO;
        end else begin
            div_q <= div_dec;
            ph_q  <= ph_dec;
        end
    end

    assign cfg_div = div_q;
    assign cfg_ph  = ph_q;

endmodule

// File: rtl/mpclk_prescale.sv
module mpclk_prescale
    import mpclk_pkg::*;
#(
    parameter int MID_RATIO  = 10,
    parameter int HIGH_RATIO = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_en,
    input  logic restart,
    input  div_e cfg_div,
    output logic ptick
);

    localparam int CNT_W = (HIGH_RATIO > 2) ? $clog2(HIGH_RATIO) : 1;
    localparam logic [CNT_W-1:0] MID_LAST  = CNT_W'(MID_RATIO - 1);
    localparam logic [CNT_W-1:0] HIGH_LAST = CNT_W'(HIGH_RATIO - 1);

    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] last;
    logic             at_last;

    always_comb begin
        case (cfg_div)
            DIV_ONE:  last = '0;
            DIV_MID:  last = MID_LAST;
            default:  last = HIGH_LAST;
        endcase
        at_last = (cnt_q == last);
        ptick   = tick_en && at_last && !restart;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (restart) begin
            cnt_q <= '0;
        end else if (tick_en) begin
            if (at_last) cnt_q <= '0;
            else         cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/mpclk_phase_fsm.sv
module mpclk_phase_fsm
    import mpclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restart,
    input  logic              ptick,
    input  ph_e               cfg_ph,
    output logic [NUM_PH-1:0] phase_out
);

    st_e               st_q;
    st_e               st_d;
    logic [NUM_PH-1:0] pat_q;
    logic [NUM_PH-1:0] pat_d;
    logic              half_q;
    logic              half_d;
    logic [NUM_PH-1:0] ring_next;
    logic [NUM_PH-1:0] twist_next;

    // Three-output ring rotation and four-output twisted ring, built per bit.
    genvar gi;
    generate
        for (gi = 0; gi < NUM_PH; gi++) begin : g_shift
            if (gi == 0) begin : g_first
                assign ring_next[gi]  = pat_q[2];
                assign twist_next[gi] = ~pat_q[NUM_PH-1];
            end else if (gi < 3) begin : g_ring
                assign ring_next[gi]  = pat_q[gi-1];
                assign twist_next[gi] = pat_q[gi-1];
            end else begin : g_spare
                assign ring_next[gi]  = 1'b0;
                assign twist_next[gi] = pat_q[gi-1];
            end
        end
    endgenerate

    // Next state
    always_comb begin
        st_d = st_q;
        if (restart) begin
            st_d = ST_IDLE;
        end else if (ptick) begin
            case (st_q)
                ST_IDLE: begin
                    case (cfg_ph)
                        PH_TWO:   st_d = ST_TWO;
                        PH_THREE: st_d = ST_THREE;
                        default:  st_d = ST_FOUR;
                    endcase
                end
                default: st_d = st_q;
            endcase
        end
    end

    // Pattern update
    always_comb begin
        pat_d  = pat_q;
        half_d = half_q;
        if (restart) begin
            pat_d  = '0;
            half_d = 1'b0;
        end else if (ptick) begin
            unique case (st_q)
                ST_IDLE: begin
                    half_d = 1'b0;
                    if (cfg_ph == PH_TWO) pat_d = 4'b0101;
                    else                  pat_d = 4'b0001;
                end
                ST_TWO:   pat_d = ~pat_q;
                ST_THREE: begin
                    half_d = ~half_q;
                    if (half_q) pat_d = ring_next;
                end
                ST_FOUR:  pat_d = twist_next;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pat_q  <= '0;
            half_q <= 1'b0;
        end else begin
            pat_q  <= pat_d;
            half_q <= half_d;
        end
    end

    assign phase_out = pat_q;

endmodule

// File: rtl/mpclk_gen.sv
module mpclk_gen
    import mpclk_pkg::*;
#(
    parameter int MID_RATIO  = 10,
    parameter int HIGH_RATIO = 100
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick_en,
    input  logic [1:0] div_code,
    input  logic [1:0] phase_code,
    output logic [3:0] phase_out
);

    div_e cfg_div;
    ph_e  cfg_ph;
    logic restart;
    logic ptick;

    mpclk_cfg u_cfg (
        .clk        (clk),
        .rst_n      (rst_n),
        .div_code   (div_code),
        .phase_code (phase_code),
        .cfg_div    (cfg_div),
        .cfg_ph     (cfg_ph),
        .restart    (restart)
    );

    mpclk_prescale #(
        .MID_RATIO  (MID_RATIO),
        .HIGH_RATIO (HIGH_RATIO)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick_en (tick_en),
        .restart (restart),
        .cfg_div (cfg_div),
        .ptick   (ptick)
    );

    mpclk_phase_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .restart   (restart),
        .ptick     (ptick),
        .cfg_ph    (cfg_ph),
        .phase_out (phase_out)
    );

endmodule

// File: rtl/mpclk_gen_chk.sv
module mpclk_gen_chk
    import mpclk_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       restart,
    input logic       ptick,
    input ph_e        cfg_ph,
    input logic [3:0] phase_out
);

    // R7
    restart_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> (phase_out == 4'b0000));

    // R9
    hold_between_ticks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ptick && !restart) |=> $stable(phase_out));

    // R4
    three_single_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ph == PH_THREE) |-> ($countones(phase_out) <= 1 && !phase_out[3]));

    // R3
    two_complement_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ph == PH_TWO && phase_out != 4'b0000) |->
        (phase_out[1] != phase_out[0] && phase_out[2] == phase_out[0] &&
         phase_out[3] == phase_out[1]));

    // R6
    single_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ph != PH_TWO && !$past(restart)) |->
        $onehot0(phase_out & ~$past(phase_out)));

    // R6
    single_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_ph != PH_TWO && !$past(restart)) |->
        $onehot0(~phase_out & $past(phase_out)));

endmodule

bind mpclk_gen mpclk_gen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .ptick     (ptick),
    .cfg_ph    (cfg_ph),
    .phase_out (phase_out)
);

// File: tb/mpclk_gen_tb.sv
`timescale 1ns/1ps
module mpclk_gen_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_en = 1'b0;
    logic [1:0] div_code = 2'b00;
    logic [1:0] phase_code = 2'b00;
    logic [3:0] phase_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    mpclk_gen u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_en    (tick_en),
        .div_code   (div_code),
        .phase_code (phase_code),
        .phase_out  (phase_out)
    );

    // Behavioural reference: tick count within group, step count since restart.
    int eff_n = 1;
    int eff_m = 0;
    int grp = 0;
    int steps = 0;
    bit rst_evt = 0;

    function automatic int want_n(input logic [1:0] c);
        return (c == 2'b00) ? 1 : (c == 2'b01) ? 10 : 100;
    endfunction

    function automatic int want_m(input logic [1:0] c);
        return (c == 2'b00) ? 0 : (c == 2'b01) ? 1 : 2;
    endfunction

    function automatic logic [3:0] ref_out(input int m, input int ev);
        logic [3:0] r;
        r = 4'b0000;
        if (ev == 0) return r;
        if (m == 0) begin
            r = (ev % 2 == 1) ? 4'b0101 : 4'b1010;
        end else if (m == 1) begin
            r[((ev - 1) / 2) % 3] = 1'b1;
        end else begin
            for (int i = 0; i < 4; i++) r[i] = (((ev + 7 - i) % 8) < 4);
        end
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            eff_n <= 1; eff_m <= 0; grp <= 0; steps <= 0; rst_evt <= 0;
        end else if (want_n(div_code) != eff_n || want_m(phase_code) != eff_m) begin
            eff_n <= want_n(div_code); eff_m <= want_m(phase_code);
            grp <= 0; steps <= 0; rst_evt <= 1;
        end else begin
            rst_evt <= 0;
            if (tick_en) begin
                if (grp + 1 == eff_n) begin
                    grp <= 0; steps <= steps + 1;
                end else begin
                    grp <= grp + 1;
                end
            end
        end
    end

    logic [3:0] prev_out = 4'b0000;

    task automatic check(input string tag, input logic [3:0] exp);
        checks++;
        if (phase_out !== exp) begin
            errors++;
            $display("FAIL %s: phase_out=%b expected %b (div %b ph %b step %0d)",
                     tag, phase_out, exp, div_code, phase_code, steps);
        end
    endtask

    // One cycle: compare at negedge, then drive next tick.
    task automatic step_cycle(input int density);
        string tag;
        logic [3:0] rises, falls;
        @(negedge clk);
        tag = (eff_m == 0) ? "R3" : (eff_m == 1) ? "R4" : "R5";
        check({tag, "/R2"}, ref_out(eff_m, steps));
        rises = phase_out & ~prev_out;
        falls = ~phase_out & prev_out;
        if (eff_m != 0 && !rst_evt) begin
            checks++;
            if ($countones(rises) > 1 || $countones(falls) > 1) begin
                errors++;
                $display("FAIL R6: rises=%b falls=%b expected at most one each",
                         rises, falls);
            end
        end
        prev_out = phase_out;
        if (density == 0)      tick_en = 1'b1;
        else if (density == 1) tick_en = ($urandom_range(0, 2) != 0);
        else                   tick_en = 1'b0;
    endtask

    task automatic change_and_check(input logic [1:0] dc, input logic [1:0] pc);
        logic restart_due;
        restart_due = (want_n(dc) != eff_n) || (want_m(pc) != eff_m);
        div_code = dc;
        phase_code = pc;
        tick_en = 1'b1;
        @(negedge clk);
        if (restart_due) check("R7", 4'b0000);
        else             check("R8", ref_out(eff_m, steps));
        prev_out = phase_out;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 4'b0000);
        rst_n = 1'b1;
        for (int k = 0; k < 20; k++) step_cycle(2);
        check("R1", 4'b0000);

        for (int pc = 0; pc < 3; pc++) begin
            for (int dc = 0; dc < 3; dc++) begin
                change_and_check(2'(dc), 2'(pc));
                for (int k = 0; k < 1700; k++) step_cycle((dc + pc) % 2);
            end
        end

        // R8: code 11 folds onto 10, no restart either way.
        change_and_check(2'b10, 2'b10);
        for (int k = 0; k < 450; k++) step_cycle(0);
        change_and_check(2'b11, 2'b11);
        for (int k = 0; k < 300; k++) step_cycle(0);
        change_and_check(2'b10, 2'b11);
        for (int k = 0; k < 300; k++) step_cycle(0);

        // R7: setting change coinciding with a completing tick (ratio 1).
        change_and_check(2'b00, 2'b10);
        for (int k = 0; k < 5; k++) step_cycle(0);
        change_and_check(2'b00, 2'b01);
        for (int k = 0; k < 30; k++) step_cycle(0);
        change_and_check(2'b01, 2'b01);
        for (int k = 0; k < 200; k++) step_cycle(0);

        // R9: no ticks, outputs hold.
        begin
            logic [3:0] held;
            step_cycle(2);
            held = phase_out;
            for (int k = 0; k < 40; k++) step_cycle(2);
            check("R9", held);
        end

        // R1: reset mid-run.
        for (int k = 0; k < 37; k++) step_cycle(0);
        rst_n = 1'b0;
        #1;
        check("R1", 4'b0000);
        @(negedge clk);
        rst_n = 1'b1;
        div_code = 2'b00;
        phase_code = 2'b00;
        prev_out = 4'b0000;
        for (int k = 0; k < 50; k++) step_cycle(0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks + 1, errors + 1);
        $finish;
    end

endmodule